// File: doc/BRIEF.md
# UART Interrupt Status Unit

This unit sits inside a UART and merges its interrupt sources into one active-high interrupt line and one 8-bit status byte. The byte names only the most urgent pending source. Neighbouring logic drives the source conditions. Line errors, transmit-holding-empty, modem changes and the two flow-control events arrive as one-cycle event pulses and are latched here. Receive-data-ready and receive-timeout arrive as live levels.

Software reads the status byte to find the source to service. A read clears only the source it reported, so any lower source appears on the next read. Two flow-control sources can interrupt only when the enhanced-features enable is set: a received Xoff or special character, and a CTS/RTS state change. The Xoff source stays pending until an Xon is received. Status reads do not clear it.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, with the FIFO enable at 0, the status byte reads 0x01 and the interrupt line is low.
- R2: The reported source is always the highest pending one, in this order from highest to lowest: line status, then receive timeout, then receive data ready, then transmit empty, then modem status, then Xoff/special character, then CTS/RTS change.
- R3: A pulse on the read strobe clears only the source being reported. All other pending sources stay pending and are reported on later reads.
- R4: Bit 0 of the status byte is active-low. It is 0 when any enabled source is pending and 1 otherwise. The interrupt line is the inverse of bit 0.
- R5: Bits 7:6 both equal the FIFO enable input.
- R6: When the enhanced enable is 0, Xoff and CTS/RTS events are ignored and bits 5:4 read 0. Turning the enable on later does not reveal those ignored events.
- R7: An Xoff event latches a source with status byte 0x10 in bits 5:0. Reads do not clear it. Only an Xon pulse clears it.
- R8: Bits 5:0 take these values: 0x06 for line status, 0x0C for receive timeout, 0x04 for receive data ready, 0x02 for transmit empty, 0x00 for modem status, 0x10 for Xoff, 0x20 for a CTS/RTS change, and 0x01 when nothing is pending.
- R9: Receive data ready and receive timeout follow their inputs. A status read does not clear them.
- R10: A transmit-empty source is cleared by a read that reports it, or by a pulse on the transmit-write input. A read that reports a higher source leaves it pending.
- R11: While the read strobe stays high, the status byte holds the value shown in the strobe's first cycle. Only one source is cleared per strobe.
- R12: A source event in the same cycle as a read that clears that source leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_en | input | 1 | FIFO mode enable, reflected in bits 7:6 |
| enh_en | input | 1 | Enhanced-features enable for the flow-control sources |
| lsr_evt | input | 1 | Line-status error event pulse |
| rx_ready | input | 1 | Receive data available (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| thr_empty_evt | input | 1 | Transmit holding register became empty (pulse) |
| thr_write | input | 1 | Write to the transmit holding register (pulse) |
| msr_evt | input | 1 | Modem-status change event pulse |
| xoff_evt | input | 1 | Xoff or special character matched (pulse) |
| xon_evt | input | 1 | Xon character received (pulse) |
| flow_chg_evt | input | 1 | CTS/RTS change-of-state event pulse |
| rd_stb | input | 1 | Status register read strobe |
| isr_q | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench tries every subset of the seven sources, with each combination of FIFO enable and enhanced enable. For each case it drains the pending set one read at a time and compares every intermediate status byte with a model computed in the bench. This separates the priority order from the code values, and it separates sources cleared by reads from level sources, which the bench drops itself. It also separates the sticky Xoff source, which needs an Xon. Directed sequences add the remaining checks:
- a held read strobe;
- an event arriving in the same cycle as the read that clears it;
- a transmit write clearing the transmit-empty source;
- flow events that arrive while the enhanced enable is off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source indices; a lower index is a higher priority.
  localparam int NSRC     = 7;
  localparam int IDXW     = $clog2(NSRC);
  localparam int I_LINE   = 0;
  localparam int I_RXTO   = 1;
  localparam int I_RXRDY  = 2;
  localparam int I_THRE   = 3;
  localparam int I_MODEM  = 4;
  localparam int I_XOFF   = 5;
  localparam int I_FLOW   = 6;

  localparam int CODEW    = 6;
  localparam int ISRW     = 8;

  // Sources that a status read may clear.
  localparam logic [NSRC-1:0] READ_CLEARABLE = 7'b1011001;

  localparam logic [CODEW-1:0] CODE_NONE = 6'h01;

  function automatic logic [CODEW-1:0] src_code(input logic [IDXW-1:0] idx);
    logic [CODEW-1:0] c;
    case (idx)
      3'd0:    c = 6'h06;
      3'd1:    c = 6'h0C;
      3'd2:    c = 6'h04;
      3'd3:    c = 6'h02;
      3'd4:    c = 6'h00;
      3'd5:    c = 6'h10;
      3'd6:    c = 6'h20;
      default: c = CODE_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/uart_irq_pend_bank.sv
module uart_irq_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic pend_d;
    logic pend_en;

    // A new event wins over a clear in the same cycle.
    always_comb begin
      pend_en = set[i] | clr[i];
      pend_d  = set[i] | (pend[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
      end else if (pend_en) begin
        pend[i] <= pend_d;
      end
    end

    // R12: an event always leaves its source pending.
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]);
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N  = 7,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  // Prefix chain: index 0 has the highest priority.
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req[i];
    assign grant[i]  = req[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = seen[N];

  // R2: at most one source is selected.
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: a source is selected whenever any source is pending.
  p_grant_when_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) == (|grant));

endmodule

// File: rtl/uart_irq_rdctl.sv
module uart_irq_rdctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_stb,
  input  logic [W-1:0] live,
  output logic         rd_start,
  output logic [W-1:0] isr_out
);

  logic         rd_q;
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    rd_start = rd_stb & ~rd_q;
    snap_d   = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (rd_start) begin
      snap_q <= snap_d;
    end
  end

  // The value from the first strobe cycle is held for the rest of the strobe.
  assign isr_out = (rd_stb & rd_q) ? snap_q : live;

  // R11: the byte stays frozen while the strobe is held.
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start ##1 rd_stb |-> isr_out == $past(live));

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       enh_en,
  input  logic       lsr_evt,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       thr_empty_evt,
  input  logic       thr_write,
  input  logic       msr_evt,
  input  logic       xoff_evt,
  input  logic       xon_evt,
  input  logic       flow_chg_evt,
  input  logic       rd_stb,
  output logic [7:0] isr_q,
  output logic       irq
);

  localparam int NLAT    = 5;
  localparam int L_LINE  = 0;
  localparam int L_THRE  = 1;
  localparam int L_MODEM = 2;
  localparam int L_XOFF  = 3;
  localparam int L_FLOW  = 4;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  logic [NLAT-1:0] lat_set;
  logic [NLAT-1:0] lat_clr;
  logic [NLAT-1:0] lat;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] rd_clr;
  logic [IDXW-1:0] top_idx;
  logic            any_req;
  logic            rd_start;
  logic [ISRW-1:0] live_isr;
  logic            unused_clr;

  // Flow-control events are ignored while enhanced features are off.
  always_comb begin
    lat_set[L_LINE]  = lsr_evt;
    lat_set[L_THRE]  = thr_empty_evt;
    lat_set[L_MODEM] = msr_evt;
    lat_set[L_XOFF]  = xoff_evt & enh_en;
    lat_set[L_FLOW]  = flow_chg_evt & enh_en;
  end

  assign rd_clr     = grant & {NSRC{rd_start}} & READ_CLEARABLE;
  assign unused_clr = rd_clr[I_RXTO] | rd_clr[I_RXRDY] | rd_clr[I_XOFF];

  always_comb begin
    lat_clr[L_LINE]  = rd_clr[I_LINE];
    lat_clr[L_THRE]  = rd_clr[I_THRE] | thr_write;
    lat_clr[L_MODEM] = rd_clr[I_MODEM];
    lat_clr[L_XOFF]  = xon_evt;
    lat_clr[L_FLOW]  = rd_clr[I_FLOW];
  end

  uart_irq_pend_bank #(.N(NLAT)) u_pend (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (lat_set),
    .clr   (lat_clr),
    .pend  (lat)
  );

  always_comb begin
    req[I_LINE]  = lat[L_LINE];
    req[I_RXTO]  = rx_timeout;
    req[I_RXRDY] = rx_ready;
    req[I_THRE]  = lat[L_THRE];
    req[I_MODEM] = lat[L_MODEM];
    req[I_XOFF]  = lat[L_XOFF] & enh_en;
    req[I_FLOW]  = lat[L_FLOW] & enh_en;
  end

  uart_irq_prio #(.N(NSRC)) u_prio (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (req),
    .grant (grant),
    .idx   (top_idx),
    .any   (any_req)
  );

  assign live_isr = {{2{fifo_en}}, (any_req ? src_code(top_idx) : CODE_NONE)};

  uart_irq_rdctl #(.W(ISRW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_stb   (rd_stb),
    .live     (live_isr),
    .rd_start (rd_start),
    .isr_out  (isr_q)
  );

  assign irq = lat[L_LINE] | lat[L_THRE] | lat[L_MODEM] | rx_ready | rx_timeout
             | (enh_en & (lat[L_XOFF] | lat[L_FLOW]));

  // R4: outside a held read, the line and bit 0 agree.
  p_irq_bit0_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_stb |-> irq == !isr_q[0]);

  // R5: the FIFO bits follow the FIFO enable.
  p_fifo_bits_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_stb |-> isr_q[7:6] == {2{fifo_en}});

  // R6: the flow-control code bits stay 0 while enhanced features are off.
  p_enh_off_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rd_stb && !enh_en) |-> isr_q[5:4] == 2'b00);

  // R7: the Xoff source stays pending until an Xon.
  p_xoff_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lat[L_XOFF] && !xon_evt) |=> lat[L_XOFF]);

  // R9: receive data ready always raises the interrupt.
  p_rx_level_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_ready |-> irq);

endmodule

// File: tb/uart_irq_status_bench.sv
`timescale 1ns/1ps
module uart_irq_status_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, enh_en = 1'b0;
  logic lsr_evt = 1'b0, rx_ready = 1'b0, rx_timeout = 1'b0;
  logic thr_empty_evt = 1'b0, thr_write = 1'b0, msr_evt = 1'b0;
  logic xoff_evt = 1'b0, xon_evt = 1'b0, flow_chg_evt = 1'b0, rd_stb = 1'b0;
  logic [7:0] isr_q;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_status u_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enh_en(enh_en),
    .lsr_evt(lsr_evt), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
    .thr_empty_evt(thr_empty_evt), .thr_write(thr_write), .msr_evt(msr_evt),
    .xoff_evt(xoff_evt), .xon_evt(xon_evt), .flow_chg_evt(flow_chg_evt),
    .rd_stb(rd_stb), .isr_q(isr_q), .irq(irq)
  );

  function automatic logic [5:0] code_of(int i);
    case (i)
      0: return 6'h06;
      1: return 6'h0C;
      2: return 6'h04;
      3: return 6'h02;
      4: return 6'h00;
      5: return 6'h10;
      6: return 6'h20;
      default: return 6'h01;
    endcase
  endfunction

  function automatic int top_of(logic [6:0] m, logic e);
    logic [6:0] r = m;
    r[5] = r[5] & e;
    r[6] = r[6] & e;
    for (int i = 0; i < 7; i++) if (r[i]) return i;
    return 7;
  endfunction

  function automatic logic [7:0] exp_isr(logic [6:0] m, logic f, logic e);
    return {f, f, code_of(top_of(m, e))};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    #1;
  endtask

  task automatic xon_pulse();
    @(negedge clk);
    xon_evt = 1'b1;
    @(negedge clk);
    xon_evt = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 status", isr_q, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // Sweep: every source subset under each enable combination (R2 R3 R4 R5 R6 R7 R8 R9).
    for (int f = 0; f < 2; f++) begin
      for (int e = 0; e < 2; e++) begin
        for (int mask = 0; mask < 128; mask++) begin
          logic [6:0] m;
          m = 7'(mask);
          m[5] = m[5] & e[0];
          m[6] = m[6] & e[0];
          fifo_en = f[0];
          enh_en  = e[0];
          do_reset();
          @(negedge clk);
          lsr_evt = mask[0]; rx_timeout = mask[1]; rx_ready = mask[2];
          thr_empty_evt = mask[3]; msr_evt = mask[4];
          xoff_evt = mask[5]; flow_chg_evt = mask[6];
          @(negedge clk);
          lsr_evt = 0; thr_empty_evt = 0; msr_evt = 0; xoff_evt = 0; flow_chg_evt = 0;
          #1;
          for (int step = 0; step < 9; step++) begin
            logic [7:0] ex;
            int t;
            ex = exp_isr(m, f[0], e[0]);
            chk("R2 R8 R5 R6 status", isr_q, ex);
            chk("R4 irq", {7'd0, irq}, {7'd0, ~ex[0]});
            t = top_of(m, e[0]);
            if (t == 7) break;
            if (t == 1) begin
              rx_timeout = 0; m[1] = 0; #1;
            end else if (t == 2) begin
              rx_ready = 0; m[2] = 0; #1;
            end else if (t == 5) begin
              read_pulse();
              chk("R7 xoff survives read", isr_q, ex);
              xon_pulse();
              m[5] = 0;
            end else begin
              read_pulse();   // R3: only the reported source clears
              m[t] = 0;
            end
          end
          rx_ready = 0; rx_timeout = 0;
        end
      end
    end

    fifo_en = 0;
    enh_en = 1;

    // R11: held strobe keeps the first value and clears once.
    do_reset();
    @(negedge clk); lsr_evt = 1; thr_empty_evt = 1;
    @(negedge clk); lsr_evt = 0; thr_empty_evt = 0;
    rd_stb = 1; #1;
    chk("R11 first cycle", isr_q, 8'h06);
    @(negedge clk); #1;
    chk("R11 held", isr_q, 8'h06);
    @(negedge clk); #1;
    chk("R11 held again", isr_q, 8'h06);
    @(negedge clk); rd_stb = 0; #1;
    chk("R11 single clear", isr_q, 8'h02);

    // R10: transmit write clears transmit-empty.
    @(negedge clk); thr_write = 1;
    @(negedge clk); thr_write = 0; #1;
    chk("R10 write clears", isr_q, 8'h01);

    // R12: event coinciding with the clearing read.
    @(negedge clk); thr_empty_evt = 1;
    @(negedge clk); thr_empty_evt = 0; rd_stb = 1; thr_empty_evt = 1;
    @(negedge clk); rd_stb = 0; thr_empty_evt = 0; #1;
    chk("R12 thre kept", isr_q, 8'h02);
    @(negedge clk); thr_write = 1; lsr_evt = 1;
    @(negedge clk); thr_write = 0; lsr_evt = 0; rd_stb = 1; lsr_evt = 1;
    @(negedge clk); rd_stb = 0; lsr_evt = 0; #1;
    chk("R12 line kept", isr_q, 8'h06);
    read_pulse();
    chk("R3 line cleared", isr_q, 8'h01);

    // R10: a read reporting a higher source leaves transmit-empty.
    @(negedge clk); lsr_evt = 1; thr_empty_evt = 1;
    @(negedge clk); lsr_evt = 0; thr_empty_evt = 0; #1;
    read_pulse();
    chk("R10 thre survives line read", isr_q, 8'h02);
    read_pulse();
    chk("R10 read clears thre", isr_q, 8'h01);

    // R9: level sources are not cleared by reads.
    rx_ready = 1; #1;
    read_pulse();
    chk("R9 ready survives read", isr_q, 8'h04);
    rx_timeout = 1; #1;
    read_pulse();
    chk("R9 timeout survives read", isr_q, 8'h0C);
    rx_ready = 0; rx_timeout = 0; #1;
    chk("R9 follows level", isr_q, 8'h01);

    // R6: events while disabled are dropped for good.
    do_reset();
    enh_en = 0;
    @(negedge clk); xoff_evt = 1; flow_chg_evt = 1;
    @(negedge clk); xoff_evt = 0; flow_chg_evt = 0; #1;
    chk("R6 disabled ignore", isr_q, 8'h01);
    chk("R6 irq low", {7'd0, irq}, 8'h00);
    enh_en = 1; #1;
    chk("R6 not revealed", isr_q, 8'h01);

    // R7: Xoff hides CTS/RTS until Xon.
    @(negedge clk); xoff_evt = 1; flow_chg_evt = 1;
    @(negedge clk); xoff_evt = 0; flow_chg_evt = 0; #1;
    read_pulse();
    read_pulse();
    chk("R7 sticky after reads", isr_q, 8'h10);
    xon_pulse();
    chk("R7 xon clears", isr_q, 8'h20);
    read_pulse();
    chk("R3 flow cleared", isr_q, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule